// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial bus slave and a storage array. While a write transaction is open, it gathers data bytes into a small page buffer. The first byte lands at the slot picked by the low bits of the start address. Each later byte lands in the next slot, wrapping inside the page. Nothing reaches storage while bytes are arriving. Only a stop condition that closes the transaction hands the buffer over to one internally timed write cycle.

During that cycle the block raises a busy flag toward the bus side, and it ignores every bus-side strobe until the cycle expires. The slave uses busy to leave device-address probes unacknowledged. In the first clocks of the cycle the block drives the storage write port with one byte per clock, and only for slots that actually received data. A repeated start without a stop, or an abort, throws the buffer away and starts no cycle.

The cycle length is a parameter counted in system clocks. It is never shorter than the page size, so every buffered byte is written before busy falls.

Top module: `pgwr_commit`

## Requirements
- R1: After synchronous reset, `busy` is low and `mem_we` is low.
- R2: The page base is the start address with its low 3 bits cleared. Data byte i of a transaction (i counting from 0) is written at page base + ((start low 3 bits + i) mod 8), so the slot index wraps inside the 8-byte page. A single byte followed by a stop is written the same way.
- R3: A 9th or later byte overwrites the slot it lands on. Only slots that received at least one byte are written, so the number of storage writes equals the number of distinct slots filled, and each write carries the last byte that slot received.
- R4: When `abort_evt` arrives before a stop, the buffer is discarded. `busy` stays low, nothing is written, and a later lone `stop_evt` writes nothing.
- R5: A stop that ends a transaction holding at least one byte makes `busy` high from the next clock. `busy` stays high for exactly WR_CYCLES clocks (at least 8), then goes low.
- R6: Storage writes occur only while `busy` is high. Within one cycle they come one per clock in ascending slot order, and all fall inside the first 8 busy clocks.
- R7: While `busy` is high, `wr_begin`, `byte_vld`, `stop_evt` and `abort_evt` have no effect. They neither lengthen the cycle nor open a transaction that a later stop could commit.
- R8: A stop that ends a transaction with no data bytes starts no cycle and writes nothing.
- R9: A `wr_begin` while a transaction is open discards the buffered bytes and restarts at the new address.
- R10: When inputs arrive together while collecting, the priority is abort, then stop, then start, then byte. A byte that arrives with a stop is dropped.
- R11: `byte_vld` and `stop_evt` with no open transaction are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_begin | input | 1 | Write transaction opened; `wr_addr` is valid |
| wr_addr | input | ADDR_W | Start address of the write |
| byte_vld | input | 1 | One data byte received |
| byte_data | input | DATA_W | Received data byte |
| stop_evt | input | 1 | Stop condition seen on the bus |
| abort_evt | input | 1 | Repeated start without a stop |
| busy | output | 1 | Timed write cycle in progress |
| mem_we | output | 1 | Storage write strobe |
| mem_addr | output | ADDR_W | Storage write address |
| mem_wdata | output | DATA_W | Storage write data |

## Verification
The state hardest to reach from the ports is a burst that wraps and overruns the page. In that case some slots hold a later byte than the first one they received, and the commit must write every slot once, in ascending order, with the newest value. The vector table reaches it with an 11-byte burst from an unaligned start and with a 2-byte burst from the last slot of the top page. A second hard case is a complete transaction driven while busy is high. The bench sends one and then issues a lone stop after busy falls, so any transaction the block had wrongly latched shows up as a new busy cycle.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    localparam int DEF_ADDR_W     = 8;
    localparam int DEF_DATA_W     = 8;
    localparam int DEF_PAGE_SLOTS = 8;
    localparam int DEF_WR_CYCLES  = 40;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FILL   = 2'd1,
        PH_COMMIT = 2'd2
    } phase_e;

    // Timed cycle is never shorter than one clock per slot.
    function automatic int busy_len(input int cycles, input int slots);
        return (cycles < slots) ? slots : cycles;
    endfunction

endpackage

// File: rtl/pgwr_slot_buf.sv
module pgwr_slot_buf #(
    parameter int DATA_W = 8,
    parameter int SLOTS  = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              any_vld
);

    logic [SLOTS-1:0]  vld_q;
    logic [DATA_W-1:0] data_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic              hit;
        logic              vld_s;
        logic [DATA_W-1:0] data_s;

        assign hit = wr_en && (wr_idx == IDX_W'(s));

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                vld_s <= 1'b0;
            end else if (hit) begin
                vld_s <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit) begin
                data_s <= wr_data;
            end
        end

        assign vld_q[s]  = vld_s;
        assign data_q[s] = data_s;
    end

    assign rd_data = data_q[rd_idx];
    assign rd_vld  = vld_q[rd_idx];
    assign any_vld = |vld_q;

endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int IDX_W    = 3,
    parameter int BUSY_LEN = 40,
    parameter int CNT_W    = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_begin,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic                    byte_vld,
    input  logic                    stop_evt,
    input  logic                    abort_evt,
    input  logic                    any_vld,
    output phase_e                  phase,
    output logic [ADDR_W-IDX_W-1:0] page_q,
    output logic [IDX_W-1:0]        fill_idx,
    output logic                    buf_clr,
    output logic                    buf_wr,
    output logic [CNT_W-1:0]        cyc_cnt
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BUSY_LEN - 1);

    phase_e                  phase_q, phase_d;
    logic [ADDR_W-IDX_W-1:0] page_d;
    logic [IDX_W-1:0]        idx_q, idx_d;
    logic [CNT_W-1:0]        cnt_q, cnt_d;

    always_comb begin
        phase_d = phase_q;
        page_d  = page_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                cnt_d = '0;
                if (wr_begin) begin
                    phase_d = PH_FILL;
                    page_d  = wr_addr[ADDR_W-1:IDX_W];
                    idx_d   = wr_addr[IDX_W-1:0];
                    buf_clr = 1'b1;
                end
            end
            PH_FILL: begin
                cnt_d = '0;
                if (abort_evt) begin
                    phase_d = PH_IDLE;
                    buf_clr = 1'b1;
                end else if (stop_evt) begin
                    phase_d = any_vld ? PH_COMMIT : PH_IDLE;
                end else if (wr_begin) begin
                    page_d  = wr_addr[ADDR_W-1:IDX_W];
                    idx_d   = wr_addr[IDX_W-1:0];
                    buf_clr = 1'b1;
                end else if (byte_vld) begin
                    buf_wr = 1'b1;
                    idx_d  = idx_q + 1'b1;
                end
            end
            PH_COMMIT: begin
                if (cnt_q == LAST_CNT) begin
                    phase_d = PH_IDLE;
                    cnt_d   = '0;
                    buf_clr = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                phase_d = PH_IDLE;
                buf_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            page_q  <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            page_q  <= page_d;
            idx_q   <= idx_d;
            cnt_q   <= cnt_d;
        end
    end

    assign phase    = phase_q;
    assign fill_idx = idx_q;
    assign cyc_cnt  = cnt_q;

endmodule

// File: rtl/pgwr_wport.sv
module pgwr_wport
    import pgwr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SLOTS  = 8,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 6
) (
    input  phase_e                  phase,
    input  logic [CNT_W-1:0]        cyc_cnt,
    input  logic [ADDR_W-IDX_W-1:0] page_q,
    input  logic [DATA_W-1:0]       slot_data,
    input  logic                    slot_vld,
    output logic [IDX_W-1:0]        scan_idx,
    output logic                    busy,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata
);

    logic in_scan;

    assign busy      = (phase == PH_COMMIT);
    assign in_scan   = busy && (cyc_cnt < CNT_W'(SLOTS));
    assign scan_idx  = cyc_cnt[IDX_W-1:0];
    assign mem_we    = in_scan && slot_vld;
    assign mem_addr  = {page_q, scan_idx};
    assign mem_wdata = slot_data;

endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int DATA_W     = DEF_DATA_W,
    parameter int PAGE_SLOTS = DEF_PAGE_SLOTS,
    parameter int WR_CYCLES  = DEF_WR_CYCLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_begin,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_evt,
    input  logic              abort_evt,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    localparam int IDX_W    = $clog2(PAGE_SLOTS);
    localparam int BUSY_LEN = busy_len(WR_CYCLES, PAGE_SLOTS);
    localparam int CNT_W    = $clog2(BUSY_LEN + 1);

    phase_e                  phase;
    logic [ADDR_W-IDX_W-1:0] page_q;
    logic [IDX_W-1:0]        fill_idx;
    logic [IDX_W-1:0]        scan_idx;
    logic                    buf_clr;
    logic                    buf_wr;
    logic                    any_vld;
    logic [CNT_W-1:0]        cyc_cnt;
    logic [DATA_W-1:0]       slot_data;
    logic                    slot_vld;

    pgwr_seq #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .BUSY_LEN(BUSY_LEN),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_begin (wr_begin),
        .wr_addr  (wr_addr),
        .byte_vld (byte_vld),
        .stop_evt (stop_evt),
        .abort_evt(abort_evt),
        .any_vld  (any_vld),
        .phase    (phase),
        .page_q   (page_q),
        .fill_idx (fill_idx),
        .buf_clr  (buf_clr),
        .buf_wr   (buf_wr),
        .cyc_cnt  (cyc_cnt)
    );

    pgwr_slot_buf #(
        .DATA_W(DATA_W),
        .SLOTS (PAGE_SLOTS),
        .IDX_W (IDX_W)
    ) u_buf (
        .clk    (clk),
        .rst    (rst),
        .clr    (buf_clr),
        .wr_en  (buf_wr),
        .wr_idx (fill_idx),
        .wr_data(byte_data),
        .rd_idx (scan_idx),
        .rd_data(slot_data),
        .rd_vld (slot_vld),
        .any_vld(any_vld)
    );

    pgwr_wport #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SLOTS (PAGE_SLOTS),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_wport (
        .phase    (phase),
        .cyc_cnt  (cyc_cnt),
        .page_q   (page_q),
        .slot_data(slot_data),
        .slot_vld (slot_vld),
        .scan_idx (scan_idx),
        .busy     (busy),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata)
    );

endmodule

// File: rtl/pgwr_commit_chk.sv
module pgwr_commit_chk #(
    parameter int ADDR_W   = 8,
    parameter int IDX_W    = 3,
    parameter int BUSY_LEN = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              stop_evt,
    input logic              abort_evt
);

    localparam int RUN_W = $clog2(BUSY_LEN + 1);

    logic [RUN_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);                                            // R6

    AST_ASCENDING_SLOTS: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |->
            (mem_addr[IDX_W-1:0] > $past(mem_addr[IDX_W-1:0])));      // R6

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_evt));                            // R5

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && (run_cnt < RUN_W'(BUSY_LEN - 1))) |=> busy);         // R5

    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
        (busy && (run_cnt == RUN_W'(BUSY_LEN - 1))) |=> !busy);       // R5

    AST_ABORT_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (!busy && abort_evt) |=> !busy);                             // R4

endmodule

bind pgwr_commit pgwr_commit_chk #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .BUSY_LEN(BUSY_LEN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .stop_evt (stop_evt),
    .abort_evt(abort_evt)
);

// File: tb/pgwr_commit_test.sv
module pgwr_commit_test;

    localparam int CYC = 12;

    typedef struct packed {
        logic [7:0] addr;
        logic [4:0] nb;
        logic [7:0] seed;
        logic       stop;
        logic [3:0] exp_writes;
        logic       exp_busy;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'h10, 5'd1,  8'hA5, 1'b1, 4'd1, 1'b1},
        '{8'h23, 5'd8,  8'h30, 1'b1, 4'd8, 1'b1},
        '{8'h46, 5'd3,  8'h70, 1'b1, 4'd3, 1'b1},
        '{8'h5D, 5'd11, 8'h90, 1'b1, 4'd8, 1'b1},
        '{8'h60, 5'd4,  8'hC0, 1'b0, 4'd0, 1'b0},
        '{8'hF9, 5'd0,  8'h00, 1'b1, 4'd0, 1'b0},
        '{8'hFF, 5'd2,  8'h11, 1'b1, 4'd2, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_begin = 1'b0;
    logic [7:0] wr_addr = '0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       stop_evt = 1'b0;
    logic       abort_evt = 1'b0;
    logic       busy;
    logic       mem_we;
    logic [7:0] mem_addr;
    logic [7:0] mem_wdata;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    logic [7:0] seen_d [256];
    bit         seen_h [256];
    int         wcount = 0;
    int         last_off = -1;
    bit         order_bad = 1'b0;

    always #4 clk = ~clk;

    pgwr_commit #(.WR_CYCLES(CYC)) uut (
        .clk(clk), .rst(rst), .wr_begin(wr_begin), .wr_addr(wr_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt),
        .abort_evt(abort_evt), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(negedge clk) begin
        if (mem_we) begin
            if (!busy) order_bad = 1'b1;
            if (wcount > 0 && int'(mem_addr[2:0]) <= last_off) order_bad = 1'b1;
            last_off = int'(mem_addr[2:0]);
            seen_d[mem_addr] = mem_wdata;
            seen_h[mem_addr] = 1'b1;
            wcount++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        for (int a = 0; a < 256; a++) begin
            seen_h[a] = 1'b0;
            seen_d[a] = '0;
        end
        wcount = 0;
        last_off = -1;
        order_bad = 1'b0;
    endtask

    task automatic drive(input bit b, input bit v, input bit s, input bit a,
                         input logic [7:0] ad, input logic [7:0] d);
        wr_begin = b; byte_vld = v; stop_evt = s; abort_evt = a;
        wr_addr = ad; byte_data = d;
        @(negedge clk);
        wr_begin = 1'b0; byte_vld = 1'b0; stop_evt = 1'b0; abort_evt = 1'b0;
    endtask

    task automatic busy_run(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [7:0] ed [8];
        bit         eh [8];
        int         n;
        int         slot;
        logic [7:0] a;
        clear_mon();
        for (int s = 0; s < 8; s++) begin
            eh[s] = 1'b0;
            ed[s] = '0;
        end
        drive(1, 0, 0, 0, v.addr, 8'h00);
        for (int i = 0; i < int'(v.nb); i++) begin
            slot = (int'(v.addr[2:0]) + i) % 8;
            ed[slot] = v.seed + 8'(i);
            eh[slot] = 1'b1;
            drive(0, 1, 0, 0, 8'h00, v.seed + 8'(i));
        end
        drive(0, 0, v.stop, !v.stop, 8'h00, 8'h00);
        chk("R5/R8 busy after end", int'(busy), int'(v.exp_busy));
        busy_run(n);
        if (v.exp_busy) chk("R5 busy length", n, CYC);
        if (!v.stop) begin
            drive(0, 0, 1, 0, 8'h00, 8'h00);
            chk("R4 lone stop after abort keeps busy low", int'(busy), 0);
        end
        chk("R3 write count", wcount, int'(v.exp_writes));
        for (int s = 0; s < 8; s++) begin
            a = {v.addr[7:3], 3'(s)};
            chk("R2 slot written", int'(seen_h[a]), int'(eh[s] && v.stop));
            if (eh[s] && v.stop)
                chk("R3 slot data", int'(seen_d[a]), int'(ed[s]));
        end
        chk("R6 ascending writes while busy", int'(order_bad), 0);
    endtask

    initial begin
        int n;
        int extra;
        clear_mon();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 mem_we after reset", int'(mem_we), 0);
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            run_vec(VECS[k]);
            @(negedge clk);
        end

        // R7: full transaction driven while busy is ignored
        clear_mon();
        drive(1, 0, 0, 0, 8'h80, 8'h00);
        drive(0, 1, 0, 0, 8'h00, 8'h5A);
        drive(0, 0, 1, 0, 8'h00, 8'h00);
        n = 0;
        if (busy) n++;
        drive(1, 0, 0, 0, 8'h90, 8'h00);
        if (busy) n++;
        drive(0, 1, 0, 0, 8'h00, 8'h11);
        if (busy) n++;
        drive(0, 1, 0, 1, 8'h00, 8'h22);
        if (busy) n++;
        drive(0, 0, 1, 0, 8'h00, 8'h00);
        busy_run(extra);
        chk("R7 busy length unchanged", n + extra, CYC);
        drive(0, 0, 1, 0, 8'h00, 8'h00);
        chk("R7 no latched transaction", int'(busy), 0);
        chk("R7 write count", wcount, 1);
        chk("R7 data at 0x80", int'(seen_d[8'h80]), 8'h5A);

        // R9: restart while collecting
        clear_mon();
        drive(1, 0, 0, 0, 8'h30, 8'h00);
        drive(0, 1, 0, 0, 8'h00, 8'hAA);
        drive(1, 0, 0, 0, 8'h44, 8'h00);
        drive(0, 1, 0, 0, 8'h00, 8'hBB);
        drive(0, 0, 1, 0, 8'h00, 8'h00);
        busy_run(n);
        chk("R9 write count", wcount, 1);
        chk("R9 old address untouched", int'(seen_h[8'h30]), 0);
        chk("R9 new address data", int'(seen_d[8'h44]), 8'hBB);

        // R10: byte together with stop is dropped
        clear_mon();
        drive(1, 0, 0, 0, 8'h50, 8'h00);
        drive(0, 1, 0, 0, 8'h00, 8'h01);
        drive(0, 1, 1, 0, 8'h00, 8'h02);
        chk("R10 stop wins busy", int'(busy), 1);
        busy_run(n);
        chk("R10 write count", wcount, 1);
        chk("R10 second slot not written", int'(seen_h[8'h51]), 0);

        // R11: byte and stop with no open transaction
        clear_mon();
        drive(0, 1, 0, 0, 8'h00, 8'h77);
        drive(0, 0, 1, 0, 8'h00, 8'h00);
        chk("R11 idle stop busy", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk("R11 idle write count", wcount, 0);

        // R1: reset in the middle of a cycle
        drive(1, 0, 0, 0, 8'h70, 8'h00);
        drive(0, 1, 0, 0, 8'h00, 8'h33);
        drive(0, 0, 1, 0, 8'h00, 8'h00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 busy after mid-cycle reset", int'(busy), 0);
        chk("R1 mem_we after mid-cycle reset", int'(mem_we), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule